// File: doc/BRIEF.md
# Dual-Source Message Send Queue

This block turns word stores from two senders, a host processor and a message coprocessor, into whole network messages. Each sender has a small address window. A store to the destination slot opens a message and names the target node. Each store to the data slot appends one 32-bit word. A store to the closing slot, whose address differs from the data slot only in bit 0, appends the final word and seals the message. The first payload word travels as the handler address that the receiving node will run. A sealed message is held in a per-sender word buffer until the shared output port is free. It then leaves as a contiguous burst, with the destination beside every word and a last-word flag on the final one.

The two senders take turns on the output port, one whole message at a time. A message addressed to this node's own ID is delivered on a local receive port and never enters the network. While a sender's queue holds a sealed message that is waiting or still being sent, the sender is not stalled. Its further stores are written instead into a memory region supplied by software, through a per-sender pointer that counts up from a base address. A message that runs past the payload limit keeps only its first words and raises a sticky length error.

Top module: `msgq_send_port`

## Requirements
- R1: After reset, no word is presented on either output port, both length-error flags are 0, no spill write is issued and both spill counts are 0.
- R2: Store offsets in a sender's window are: 0 writes the destination node ID (low NODE_W bits) and opens a message, 2 appends a data word, 3 appends a data word and closes the message. A store to offset 1 has no effect. A data store that arrives while no message is open has no effect.
- R3: A message is sent only after its closing store. Its words appear in store order, one per cycle, with its destination on every word and the last flag set only on the final word. The first word is the handler address as stored.
- R4: A message that receives more than MAX_WORDS (default 20) data words keeps the first MAX_WORDS, drops the rest and is still sent once closed. The sender's length-error flag is set and stays set until reset.
- R5: The output port is shared round-robin at message granularity. After a message from one sender has been sent, the other sender wins the next contention, where sender 0 is the host and sender 1 the coprocessor, and sender 0 wins first after reset. Words of two messages never interleave.
- R6: A message whose destination equals `my_node` appears only on the local port. Any other message appears only on the network port.
- R7: While a sender's message is sealed and not yet fully read out, each store to offset 0, 2 or 3 from that sender is written instead to spill address base + count with the stored data, and the count then increments. A store to offset 1 is never spilled.
- R8: A destination store to an open, unclosed message discards the words gathered so far and restarts the message with the new destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_we | input | 2 | Store strobe per sender (0 host, 1 coprocessor) |
| st_off | input | 2x2 | Word offset of each sender's store |
| st_data | input | 2x32 | Store data per sender |
| spill_base | input | 2xSPILL_AW | Spill region base word address per sender |
| my_node | input | NODE_W | ID of this node |
| net_valid | output | 1 | Network port word valid |
| net_dest | output | NODE_W | Destination node of the current word |
| net_data | output | 32 | Network port word |
| net_last | output | 1 | Final word of the message |
| loc_valid | output | 1 | Local receive word valid |
| loc_data | output | 32 | Local receive word |
| loc_last | output | 1 | Final word of the local message |
| spill_we | output | 2 | Spill write strobe per sender |
| spill_addr | output | 2xSPILL_AW | Spill write word address per sender |
| spill_data | output | 2x32 | Spill write data per sender |
| spill_cnt | output | 2xSPILL_AW | Spill words written per sender |
| len_err | output | 2 | Sticky over-length flag per sender |

## Verification
The hardest case to reach is a true tie at the port: both senders must seal a message on the same clock edge while the round-robin pointer already favours the coprocessor. The bench sends one lone host message to move the pointer, then opens messages on both senders and issues both closing stores on the same cycle. Spill redirection needs a sealed message to still be draining when the next store arrives. The bench therefore seals a full-length message and stores into the same window on the following cycles, while the port is still reading out.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam logic [1:0] OFF_DEST  = 2'b00;
  localparam logic [1:0] OFF_DATA  = 2'b10;
  localparam logic [1:0] OFF_CLOSE = 2'b11;
endpackage

// File: rtl/msgq_front.sv
module msgq_front #(
  parameter int DW        = 32,
  parameter int NODE_W    = 8,
  parameter int MAX_WORDS = 20,
  parameter int SPILL_AW  = 16,
  parameter int IW        = $clog2(MAX_WORDS),
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          off,
  input  logic [DW-1:0]       wdata,
  input  logic [SPILL_AW-1:0] spill_base,
  input  logic                rd_en,
  input  logic [IW-1:0]       rd_idx,
  input  logic                drain_done,
  output logic                sealed,
  output logic [NODE_W-1:0]   dest,
  output logic [CW-1:0]       len,
  output logic [DW-1:0]       rdata,
  output logic                err,
  output logic                spill_we,
  output logic [SPILL_AW-1:0] spill_addr,
  output logic [DW-1:0]       spill_data,
  output logic [SPILL_AW-1:0] spill_cnt
);
  import msgq_pkg::*;

  logic [DW-1:0] words [MAX_WORDS];
  logic          open_q;
  logic          is_dest, is_data, is_close, room, mem_we;

  assign is_dest  = (off == OFF_DEST);
  assign is_data  = off[1];
  assign is_close = (off == OFF_CLOSE);
  assign room     = (len < CW'(MAX_WORDS));
  assign mem_we   = we && !sealed && open_q && is_data && room;

  // Buffer kept as a plain synchronous RAM: one write port, registered read.
  always_ff @(posedge clk) begin
    if (mem_we) words[len[IW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= words[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len        <= '0;
      open_q     <= 1'b0;
      sealed     <= 1'b0;
      dest       <= '0;
      err        <= 1'b0;
      spill_we   <= 1'b0;
      spill_addr <= '0;
      spill_data <= '0;
      spill_cnt  <= '0;
    end else begin
      spill_we <= 1'b0;
      if (drain_done) begin
        sealed <= 1'b0;
        len    <= '0;
      end
      if (we) begin
        if (sealed && (is_dest || is_data)) begin
          spill_we   <= 1'b1;
          spill_addr <= spill_base + spill_cnt;
          spill_data <= wdata;
          spill_cnt  <= spill_cnt + 1'b1;
        end else if (!sealed && is_dest) begin
          dest   <= wdata[NODE_W-1:0];
          len    <= '0;
          open_q <= 1'b1;
        end else if (!sealed && open_q && is_data) begin
          if (room) len <= len + 1'b1;
          else      err <= 1'b1;
          if (is_close) begin
            sealed <= 1'b1;
            open_q <= 1'b0;
          end
        end
      end
    end
  end

  // R4: gathered length never passes the payload limit
  a_r4_len_cap: assert property (@(posedge clk) disable iff (rst)
    len <= CW'(MAX_WORDS));
  // R4: the length error is sticky
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R7: a store to a sealed queue becomes a spill write on the next cycle
  a_r7_spill: assert property (@(posedge clk) disable iff (rst)
    (we && sealed && off != 2'b01) |=> spill_we);
  // R7: every spill write advances the count by one
  a_r7_cnt_step: assert property (@(posedge clk) disable iff (rst)
    spill_we |-> spill_cnt == $past(spill_cnt) + 1'b1);
endmodule

// File: rtl/msgq_arb.sv
module msgq_arb #(
  parameter int NODE_W    = 8,
  parameter int MAX_WORDS = 20,
  parameter int IW        = $clog2(MAX_WORDS),
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             sealed,
  input  logic [1:0][CW-1:0]     len,
  input  logic [1:0][NODE_W-1:0] dest,
  output logic [1:0]             rd_en,
  output logic [IW-1:0]          rd_idx,
  output logic [1:0]             drain_done,
  output logic                   s1_valid,
  output logic                   s1_last,
  output logic                   s1_sel,
  output logic [NODE_W-1:0]      s1_dest
);
  logic              busy, sel, pri, pick, grant, fin;
  logic [CW-1:0]     idx, cur_len;
  logic [NODE_W-1:0] cur_dest;

  always_comb begin
    grant = 1'b0;
    pick  = pri;
    if (sealed[pri]) begin
      grant = 1'b1;
    end else if (sealed[~pri]) begin
      grant = 1'b1;
      pick  = ~pri;
    end
  end

  assign fin        = busy && (idx == cur_len - 1'b1);
  assign rd_en      = {busy && sel, busy && !sel};
  assign rd_idx     = idx[IW-1:0];
  assign drain_done = {fin && sel, fin && !sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sel      <= 1'b0;
      pri      <= 1'b0;
      idx      <= '0;
      cur_len  <= '0;
      cur_dest <= '0;
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_sel   <= 1'b0;
      s1_dest  <= '0;
    end else begin
      if (!busy && grant) begin
        busy     <= 1'b1;
        sel      <= pick;
        idx      <= '0;
        cur_len  <= len[pick];
        cur_dest <= dest[pick];
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (fin) begin
          busy <= 1'b0;
          pri  <= ~sel;
        end
      end
      s1_valid <= busy;
      s1_last  <= fin;
      s1_sel   <= sel;
      s1_dest  <= cur_dest;
    end
  end

  // R5: the owner of the port cannot change in the middle of a message
  a_r5_no_switch: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> (busy && $stable(sel)));
endmodule

// File: rtl/msgq_send_port.sv
module msgq_send_port #(
  parameter int DW        = 32,
  parameter int NODE_W    = 8,
  parameter int MAX_WORDS = 20,
  parameter int SPILL_AW  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               st_we,
  input  logic [1:0][1:0]          st_off,
  input  logic [1:0][DW-1:0]       st_data,
  input  logic [1:0][SPILL_AW-1:0] spill_base,
  input  logic [NODE_W-1:0]        my_node,
  output logic                     net_valid,
  output logic [NODE_W-1:0]        net_dest,
  output logic [DW-1:0]            net_data,
  output logic                     net_last,
  output logic                     loc_valid,
  output logic [DW-1:0]            loc_data,
  output logic                     loc_last,
  output logic [1:0]               spill_we,
  output logic [1:0][SPILL_AW-1:0] spill_addr,
  output logic [1:0][DW-1:0]       spill_data,
  output logic [1:0][SPILL_AW-1:0] spill_cnt,
  output logic [1:0]               len_err
);
  localparam int IW = $clog2(MAX_WORDS);
  localparam int CW = $clog2(MAX_WORDS + 1);

  logic [1:0]             sealed, rd_en, drain_done;
  logic [1:0][CW-1:0]     len;
  logic [1:0][NODE_W-1:0] dest;
  logic [1:0][DW-1:0]     rdata;
  logic [IW-1:0]          rd_idx;
  logic                   s1_valid, s1_last, s1_sel, to_self;
  logic [NODE_W-1:0]      s1_dest;

  for (genvar q = 0; q < 2; q++) begin : g_src
    msgq_front #(.DW(DW), .NODE_W(NODE_W), .MAX_WORDS(MAX_WORDS),
                 .SPILL_AW(SPILL_AW), .IW(IW), .CW(CW)) i_front (
      .clk(clk), .rst(rst), .we(st_we[q]), .off(st_off[q]), .wdata(st_data[q]),
      .spill_base(spill_base[q]), .rd_en(rd_en[q]), .rd_idx(rd_idx),
      .drain_done(drain_done[q]), .sealed(sealed[q]), .dest(dest[q]),
      .len(len[q]), .rdata(rdata[q]), .err(len_err[q]),
      .spill_we(spill_we[q]), .spill_addr(spill_addr[q]),
      .spill_data(spill_data[q]), .spill_cnt(spill_cnt[q]));
  end

  msgq_arb #(.NODE_W(NODE_W), .MAX_WORDS(MAX_WORDS), .IW(IW), .CW(CW)) i_arb (
    .clk(clk), .rst(rst), .sealed(sealed), .len(len), .dest(dest),
    .rd_en(rd_en), .rd_idx(rd_idx), .drain_done(drain_done),
    .s1_valid(s1_valid), .s1_last(s1_last), .s1_sel(s1_sel), .s1_dest(s1_dest));

  assign to_self = (s1_dest == my_node);

  always_ff @(posedge clk) begin
    if (rst) begin
      net_valid <= 1'b0;
      net_dest  <= '0;
      net_data  <= '0;
      net_last  <= 1'b0;
      loc_valid <= 1'b0;
      loc_data  <= '0;
      loc_last  <= 1'b0;
    end else begin
      net_valid <= s1_valid && !to_self;
      net_last  <= s1_valid && s1_last && !to_self;
      net_dest  <= s1_dest;
      net_data  <= rdata[s1_sel];
      loc_valid <= s1_valid && to_self;
      loc_last  <= s1_valid && s1_last && to_self;
      loc_data  <= rdata[s1_sel];
    end
  end

  // R6: a word never appears on both ports
  a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
    !(net_valid && loc_valid));
  // R6: nothing for this node leaves through the network
  a_r6_no_self_net: assert property (@(posedge clk) disable iff (rst)
    net_valid |-> net_dest != $past(my_node));
  // R3: buffers are read only while their message is sealed
  a_r3_read_sealed: assert property (@(posedge clk) disable iff (rst)
    (rd_en & ~sealed) == 2'b00);
endmodule

// File: tb/test_msgq_send_port.sv
module test_msgq_send_port;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       st_we = '0;
  logic [1:0][1:0]  st_off = '0;
  logic [1:0][31:0] st_data = '0;
  logic [1:0][15:0] spill_base;
  logic [7:0]       my_node = 8'h09;
  logic             net_valid, net_last, loc_valid, loc_last;
  logic [7:0]       net_dest;
  logic [31:0]      net_data, loc_data;
  logic [1:0]       spill_we, len_err;
  logic [1:0][15:0] spill_addr, spill_cnt;
  logic [1:0][31:0] spill_data;

  int tests = 0, fails = 0;
  logic [31:0] cap_data [0:255];
  logic [7:0]  cap_dest [0:255];
  logic        cap_last [0:255];
  logic        cap_loc  [0:255];
  int ncap = 0;
  int          sp_hits [0:1];
  logic [15:0] sp_addr [0:1];
  logic [31:0] sp_data [0:1];

  always #5 clk = ~clk;

  msgq_send_port i_msgq_send_port (
    .clk(clk), .rst(rst), .st_we(st_we), .st_off(st_off), .st_data(st_data),
    .spill_base(spill_base), .my_node(my_node), .net_valid(net_valid),
    .net_dest(net_dest), .net_data(net_data), .net_last(net_last),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_last(loc_last),
    .spill_we(spill_we), .spill_addr(spill_addr), .spill_data(spill_data),
    .spill_cnt(spill_cnt), .len_err(len_err));

  initial begin
    sp_hits[0] = 0; sp_hits[1] = 0;
    spill_base[0] = 16'h1000;
    spill_base[1] = 16'h2000;
  end

  always @(negedge clk) begin
    if (!rst && net_valid && ncap < 256) begin
      cap_data[ncap] = net_data; cap_dest[ncap] = net_dest;
      cap_last[ncap] = net_last; cap_loc[ncap] = 1'b0; ncap = ncap + 1;
    end
    if (!rst && loc_valid && ncap < 256) begin
      cap_data[ncap] = loc_data; cap_dest[ncap] = 8'h09;
      cap_last[ncap] = loc_last; cap_loc[ncap] = 1'b1; ncap = ncap + 1;
    end
    for (int q = 0; q < 2; q++) begin
      if (!rst && spill_we[q]) begin
        sp_hits[q] = sp_hits[q] + 1; sp_addr[q] = spill_addr[q]; sp_data[q] = spill_data[q];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(input int q, input logic [1:0] off, input logic [31:0] d);
    @(negedge clk);
    st_we[q] = 1'b1; st_off[q] = off; st_data[q] = d;
    @(negedge clk);
    st_we[q] = 1'b0;
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 net_valid", {31'd0, net_valid}, 0);
    check("R1 loc_valid", {31'd0, loc_valid}, 0);
    check("R1 len_err", {30'd0, len_err}, 0);
    check("R1 spill_we", {30'd0, spill_we}, 0);
    check("R1 spill_cnt0", {16'd0, spill_cnt[0]}, 0);
    check("R1 spill_cnt1", {16'd0, spill_cnt[1]}, 0);
  endtask

  task automatic t_basic();
    int b = ncap;
    store(0, 2'b00, 32'h0000_0005);
    store(0, 2'b10, 32'h0000_0100);
    store(0, 2'b10, 32'hA1);
    repeat (10) @(negedge clk);
    check("R3 nothing before close", ncap - b, 0);
    store(0, 2'b11, 32'hA2);
    drain();
    check("R3 word count", ncap - b, 3);
    check("R3 handler word first", cap_data[b], 32'h100);
    check("R2 data order", cap_data[b+1], 32'hA1);
    check("R2 closing word", cap_data[b+2], 32'hA2);
    check("R3 dest", {24'd0, cap_dest[b+1]}, 5);
    check("R3 last only at end", {29'd0, cap_last[b], cap_last[b+1], cap_last[b+2]}, 1);
    check("R6 network port", {31'd0, cap_loc[b]}, 0);
  endtask

  task automatic t_ignored();
    int b = ncap;
    store(1, 2'b10, 32'hDEAD);
    store(1, 2'b11, 32'hBEEF);
    store(1, 2'b01, 32'h0000_0033);
    drain();
    check("R2 data without dest ignored", ncap - b, 0);
    store(1, 2'b00, 32'h0000_0044);
    store(1, 2'b01, 32'hBAD0);
    store(1, 2'b11, 32'h0000_0200);
    drain();
    check("R2 offset 1 ignored count", ncap - b, 1);
    check("R2 offset 1 ignored data", cap_data[b], 32'h200);
    check("R2 dest kept", {24'd0, cap_dest[b]}, 32'h44);
    check("R7 no spill from ignored stores", sp_hits[1], 0);
  endtask

  task automatic t_long();
    int b = ncap;
    store(1, 2'b00, 32'h0000_0021);
    for (int i = 0; i < 21; i++) store(1, 2'b10, 32'hC00 + i);
    store(1, 2'b11, 32'hC15);
    drain();
    check("R4 truncated count", ncap - b, 20);
    check("R4 last kept word", cap_data[b+19], 32'hC13);
    check("R4 last flag", {31'd0, cap_last[b+19]}, 1);
    check("R4 err set", {30'd0, len_err}, 2'b10);
    b = ncap;
    store(1, 2'b00, 32'h0000_0022);
    store(1, 2'b11, 32'h0000_0300);
    drain();
    check("R4 short message after error", ncap - b, 1);
    check("R4 err sticky", {30'd0, len_err}, 2'b10);
  endtask

  task automatic t_round_robin();
    int b;
    store(0, 2'b00, 32'h0000_0001);
    store(0, 2'b11, 32'h0000_0400);
    drain();
    b = ncap;
    store(0, 2'b00, 32'h0000_0011);
    store(1, 2'b00, 32'h0000_0022);
    store(0, 2'b10, 32'h0000_0500);
    store(1, 2'b10, 32'h0000_0600);
    @(negedge clk);
    st_we = 2'b11; st_off[0] = 2'b11; st_off[1] = 2'b11;
    st_data[0] = 32'h501; st_data[1] = 32'h601;
    @(negedge clk);
    st_we = 2'b00;
    drain();
    check("R5 four words", ncap - b, 4);
    check("R5 coprocessor wins tie", {24'd0, cap_dest[b]}, 32'h22);
    check("R5 no interleave", {cap_data[b+1][15:0], cap_data[b+2][15:0]}, 32'h0601_0500);
    check("R5 host follows", {24'd0, cap_dest[b+3]}, 32'h11);
  endtask

  task automatic t_local();
    int b = ncap;
    store(1, 2'b00, 32'h0000_0009);
    store(1, 2'b10, 32'h0000_0700);
    store(1, 2'b11, 32'h0000_0701);
    drain();
    check("R6 local count", ncap - b, 2);
    check("R6 local port only", {30'd0, cap_loc[b], cap_loc[b+1]}, 3);
    check("R6 local last", {31'd0, cap_last[b+1]}, 1);
  endtask

  task automatic t_spill();
    int b = ncap;
    store(0, 2'b00, 32'h0000_0007);
    for (int i = 0; i < 19; i++) store(0, 2'b10, 32'hE00 + i);
    store(0, 2'b11, 32'hE13);
    store(0, 2'b10, 32'hF0);
    store(0, 2'b01, 32'hF9);
    store(0, 2'b00, 32'hF1);
    store(0, 2'b11, 32'hF2);
    drain();
    check("R7 spill count", {16'd0, spill_cnt[0]}, 3);
    check("R7 spill writes", sp_hits[0], 3);
    check("R7 spill addr", {16'd0, sp_addr[0]}, 32'h1002);
    check("R7 spill data", sp_data[0], 32'hF2);
    check("R7 message intact", ncap - b, 20);
    check("R7 message tail", cap_data[b+19], 32'hE13);
  endtask

  task automatic t_restart();
    int b = ncap;
    store(0, 2'b00, 32'h0000_0003);
    store(0, 2'b10, 32'hAA);
    store(0, 2'b10, 32'hBB);
    store(0, 2'b00, 32'h0000_0004);
    store(0, 2'b11, 32'hCC);
    drain();
    check("R8 one word after restart", ncap - b, 1);
    check("R8 word", cap_data[b], 32'hCC);
    check("R8 new dest", {24'd0, cap_dest[b]}, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignored();
    t_long();
    t_round_robin();
    t_local();
    t_spill();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule